// File: doc/BRIEF.md
# 1-Wire Bit-Slot Master Engine

This block is a command-driven master for a single-wire open-drain bus. Software presents a 4-bit opcode and an 8-bit transmit value, then raises GO. The engine then runs one of five instructions: a bus reset with presence detection, a single write slot, a single read slot, or eight write or read slots that move a whole byte, least-significant bit first. All slot timing counts microseconds. A microsecond tick comes from dividing the system clock by `CLK_DIV`, whose default of 100 suits a 100 MHz clock.

The engine drives the pad output enable: 1 pulls the line low, and 0 releases it to the external pull-up. It samples the pad level through a two-stage synchronizer. When an instruction finishes, the engine stores the received bits and raises DONE. READY is the acceptance flag. It falls when an instruction starts and stays low until software withdraws GO. An active-high soft reset abandons any instruction in progress and releases the line.

Top module: `onewire_slot_engine`

## Requirements
- R1: After reset, ready is 1, done is 0, bus_oe is 0, rx_data is 0x00 and presence_n is 0.
- R2: Opcodes are 4'b1000 reset/presence, 4'b1110 write bit, 4'b1100 read bit, 4'b1111 write byte and 4'b1101 read byte. Any other opcode finishes at once with done and no bus activity, and leaves rx_data unchanged.
- R3: Every timed interval is a whole number of microseconds, each CLK_DIV clock cycles long. From the GO edge to done, a single slot takes (70+5)·CLK_DIV+1 cycles, a byte 8·75·CLK_DIV+1 cycles and a reset 960·CLK_DIV+1 cycles.
- R4: Reset/presence holds the line low for 480 µs, releases it, samples it 70 µs after release, and ends 480 µs after release. presence_n is 0 when the line was low at the sample (device answered) and 1 otherwise.
- R5: A write-bit sends only tx_data bit 0. A 1 is a 6 µs low pulse and a 0 is a 60 µs low pulse, inside a 70 µs slot.
- R6: A write-byte sends tx_data bits 0 to 7 in that order. Successive slot starts are 75 µs apart (70 µs slot plus 5 µs recovery).
- R7: A read-bit drives a 6 µs low pulse whatever tx_data holds. It samples the line 15 µs after slot start and writes that bit to rx_data bit 0, with bits 7:1 cleared.
- R8: A read-byte performs eight such read slots. The first sampled bit lands in rx_data bit 0. rx_data changes only when the instruction finishes.
- R9: An instruction starts only on a rising edge of go while ready is 1. ready stays 0 during execution and afterwards for as long as go stays 1.
- R10: done rises when execution ends and stays 1 until go is 0. It is 0 one cycle after go falls.
- R11: soft_rst releases the line and returns the engine to idle in the next cycle, with done 0. A go rising edge in the same cycle as soft_rst is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Instruction code, captured at start |
| tx_data | input | 8 | Bits to transmit, captured at start |
| go | input | 1 | Start request; its rising edge launches an instruction |
| soft_rst | input | 1 | Synchronous abort to idle, active high |
| rx_data | output | 8 | Bits received by the last read instruction |
| presence_n | output | 1 | 0 when a device answered the last reset, 1 when none did |
| ready | output | 1 | Engine idle and able to accept an instruction |
| done | output | 1 | Last instruction finished, held until go is withdrawn |
| bus_oe | output | 1 | Pad output enable; 1 pulls the line low |
| bus_in | input | 1 | Raw pad level, synchronized inside |

## Verification
Two functions can coincide in one cycle: the soft abort and the launch of an instruction. The bench raises go in the same cycle that soft_rst is pulsed. The case passes only if no low pulse appears on the line afterwards, done stays 0, and only a fresh go edge starts an instruction. A second collision aborts a reset pulse partway through its low phase. The bench then expects the line to be released in the next cycle and a normal write slot to follow cleanly. The scoreboard matches every low pulse against a queued width and slot spacing, so any stray pulse counts as a failure.

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine #(
  parameter int CLK_DIV    = 100,
  parameter int T_RST_LOW  = 480,
  parameter int T_PRES_SMP = 70,
  parameter int T_RST_HIGH = 480,
  parameter int T_SLOT     = 70,
  parameter int T_LOW_ONE  = 6,
  parameter int T_LOW_ZERO = 60,
  parameter int T_RD_SMP   = 15,
  parameter int T_RECOV    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  input  logic [7:0] tx_data,
  input  logic       go,
  input  logic       soft_rst,
  output logic [7:0] rx_data,
  output logic       presence_n,
  output logic       ready,
  output logic       done,
  output logic       bus_oe,
  input  logic       bus_in
);
  localparam int DW   = $clog2(CLK_DIV + 1);
  localparam int TMX1 = (T_RST_LOW > T_RST_HIGH) ? T_RST_LOW : T_RST_HIGH;
  localparam int TMAX = (TMX1 > T_SLOT) ? TMX1 : T_SLOT;
  localparam int UW   = $clog2(TMAX + 1);
  localparam logic [3:0] OP_RST   = 4'b1000;
  localparam logic [3:0] OP_WBIT  = 4'b1110;
  localparam logic [3:0] OP_RBIT  = 4'b1100;
  localparam logic [3:0] OP_WBYTE = 4'b1111;
  localparam logic [3:0] OP_RBYTE = 4'b1101;

  typedef enum logic [2:0] {S_IDLE, S_RLOW, S_RHIGH, S_SLOT, S_RECOV, S_HOLD} st_t;

  st_t           st;
  logic [DW-1:0] div_cnt;
  logic [UW-1:0] us_cnt, plen, lowlen;
  logic [1:0]    sync;
  logic [7:0]    tx_sh, rx_sh;
  logic [3:0]    left;
  logic          go_q, rd_op, byte_op;
  logic          tick, pend, launch, oe_nx, idle_like;

  assign tick      = div_cnt == DW'(CLK_DIV - 1);
  assign idle_like = (st == S_IDLE) || (st == S_HOLD);
  assign launch    = go && !go_q && (st == S_IDLE) && !soft_rst;
  assign ready     = (st == S_IDLE) && !soft_rst;
  assign done      = st == S_HOLD;
  assign pend      = tick && (us_cnt == plen - 1'b1);
  assign lowlen    = (rd_op || tx_sh[0]) ? UW'(T_LOW_ONE) : UW'(T_LOW_ZERO);
  assign oe_nx     = (st == S_RLOW) || ((st == S_SLOT) && (us_cnt < lowlen));

  always_comb begin
    case (st)
      S_RLOW:  plen = UW'(T_RST_LOW);
      S_RHIGH: plen = UW'(T_RST_HIGH);
      S_SLOT:  plen = UW'(T_SLOT);
      S_RECOV: plen = UW'(T_RECOV);
      default: plen = UW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], bus_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      div_cnt    <= '0;
      us_cnt     <= '0;
      go_q       <= 1'b0;
      bus_oe     <= 1'b0;
      rx_data    <= 8'h00;
      presence_n <= 1'b0;
      tx_sh      <= 8'h00;
      rx_sh      <= 8'h00;
      left       <= 4'd0;
      rd_op      <= 1'b0;
      byte_op    <= 1'b0;
    end else begin
      go_q <= go;
      if (soft_rst) begin
        st      <= S_IDLE;
        div_cnt <= '0;
        us_cnt  <= '0;
        bus_oe  <= 1'b0;
      end else begin
        bus_oe <= oe_nx;
        if (idle_like || tick) div_cnt <= '0;
        else                   div_cnt <= div_cnt + 1'b1;
        if (idle_like || pend) us_cnt <= '0;
        else if (tick)         us_cnt <= us_cnt + 1'b1;
        case (st)
          S_IDLE: if (launch) begin
            tx_sh <= tx_data;
            rx_sh <= 8'h00;
            case (opcode)
              OP_RST:   st <= S_RLOW;
              OP_WBIT:  begin rd_op <= 1'b0; byte_op <= 1'b0; left <= 4'd1; st <= S_SLOT; end
              OP_RBIT:  begin rd_op <= 1'b1; byte_op <= 1'b0; left <= 4'd1; st <= S_SLOT; end
              OP_WBYTE: begin rd_op <= 1'b0; byte_op <= 1'b1; left <= 4'd8; st <= S_SLOT; end
              OP_RBYTE: begin rd_op <= 1'b1; byte_op <= 1'b1; left <= 4'd8; st <= S_SLOT; end
              default:  st <= S_HOLD;
            endcase
          end
          S_RLOW: if (pend) st <= S_RHIGH;
          S_RHIGH: begin
            if (tick && us_cnt == UW'(T_PRES_SMP - 1)) presence_n <= sync[1];
            if (pend) st <= S_HOLD;
          end
          S_SLOT: begin
            if (rd_op && tick && us_cnt == UW'(T_RD_SMP - 1)) rx_sh <= {sync[1], rx_sh[7:1]};
            if (pend) begin
              tx_sh <= tx_sh >> 1;
              left  <= left - 1'b1;
              st    <= S_RECOV;
            end
          end
          S_RECOV: if (pend) begin
            if (left == 4'd0) begin
              st <= S_HOLD;
              if (rd_op) rx_data <= byte_op ? rx_sh : {7'b0, rx_sh[7]};
            end else begin
              st <= S_SLOT;
            end
          end
          S_HOLD: if (!go) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_WHILE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && go && !soft_rst) |=> (done && !ready)); // R9
  AST_PULSE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> !ready); // R9
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> !done); // R10
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!bus_oe && !done)); // R11
  AST_RX_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(rx_data)); // R8
  AST_PRES_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence_n) |-> $past(st == S_RHIGH)); // R4
endmodule

// File: tb/onewire_slot_engine_bench.sv
`timescale 1ns/1ps
module onewire_slot_engine_bench;
  localparam int DIV    = 4;
  localparam int CLK_NS = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, go, soft_rst, bus_oe, bus_in, ready, done, presence_n;
  logic [3:0] opcode;
  logic [7:0] tx_data, rx_data;
  logic       pull_r = 1'b0, pull_p = 1'b0;
  assign bus_in = !(bus_oe || pull_r || pull_p);

  int    tests = 0, errs = 0;
  int    exp_w[$], exp_p[$];
  string exp_t[$];
  int    dev_mode = 0, dev_idx = 0;
  logic [7:0] dev_bits = 8'h00;

  onewire_slot_engine #(.CLK_DIV(DIV)) u_onewire_slot_engine (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .tx_data(tx_data), .go(go),
    .soft_rst(soft_rst), .rx_data(rx_data), .presence_n(presence_n),
    .ready(ready), .done(done), .bus_oe(bus_oe), .bus_in(bus_in));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int w, input int p, input string tag);
    exp_w.push_back(w); exp_p.push_back(p); exp_t.push_back(tag);
  endtask

  // device model: answers reset with a presence pulse, drives read slots
  initial forever begin
    @(posedge bus_oe);
    if (dev_mode == 2) begin
      if (!dev_bits[dev_idx]) begin
        pull_r = 1'b1;
        repeat (30 * DIV) @(posedge clk);
        pull_r = 1'b0;
      end
      dev_idx++;
    end
  end
  initial forever begin
    @(negedge bus_oe);
    if (dev_mode == 1) begin
      repeat (15 * DIV) @(posedge clk);
      pull_p = 1'b1;
      repeat (120 * DIV) @(posedge clk);
      pull_p = 1'b0;
    end
  end

  // monitor: pops expected low pulses and compares width and spacing
  initial begin
    time tr, prev;
    int  w, per, ew, ep;
    string tg;
    prev = 0;
    forever begin
      @(posedge bus_oe);
      tr  = $time;
      per = int'((tr - prev) / CLK_NS);
      prev = tr;
      @(negedge bus_oe);
      w = int'(($time - tr) / CLK_NS);
      if (exp_w.size() == 0) begin
        chk(1'b0, "R2 unexpected pulse", w, 0);
      end else begin
        ew = exp_w.pop_front(); ep = exp_p.pop_front(); tg = exp_t.pop_front();
        if (ew >= 0) chk(w == ew, {tg, " pulse width"}, w, ew);
        if (ep > 0)  chk(per == ep, {tg, " slot spacing"}, per, ep);
      end
    end
  end

  task automatic run_op(input logic [3:0] op, input logic [7:0] d, output int cyc);
    @(negedge clk);
    opcode = op; tx_data = d; go = 1'b1; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!done && cyc < 20000);
  endtask

  task automatic finish_op();
    repeat (20) @(negedge clk);
    chk(ready == 1'b0 && done == 1'b1, "R9 held while go high", int'(ready), 0);
    go = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done after go low", int'(done), 0);
    chk(ready == 1'b1, "R9 ready after go low", int'(ready), 1);
    repeat (10) @(negedge clk);
    chk(exp_w.size() == 0, "R2 scoreboard drained", exp_w.size(), 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; errs++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int c;
    logic [7:0] pat;
    rst_n = 1'b0; go = 1'b0; soft_rst = 1'b0; opcode = 4'h0; tx_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0, "R1 ready/done", {ready, done}, 2);
    chk(bus_oe == 1'b0, "R1 bus released", int'(bus_oe), 0);
    chk(rx_data == 8'h00 && presence_n == 1'b0, "R1 rx/presence", int'(rx_data), 0);

    // R4 reset with a device answering
    dev_mode = 1; push(480 * DIV, 0, "R4");
    run_op(4'b1000, 8'h00, c);
    chk(c == 960 * DIV + 1, "R3 reset duration", c, 960 * DIV + 1);
    chk(presence_n == 1'b0, "R4 device present", int'(presence_n), 0);
    finish_op();

    // R4 reset with nobody on the line
    dev_mode = 0; push(480 * DIV, 0, "R4");
    run_op(4'b1000, 8'h00, c);
    chk(presence_n == 1'b1, "R4 no device", int'(presence_n), 1);
    finish_op();

    // R5 write bit: only bit 0 matters
    push(60 * DIV, 0, "R5");
    run_op(4'b1110, 8'hFE, c);
    chk(c == 75 * DIV + 1, "R3 bit slot duration", c, 75 * DIV + 1);
    finish_op();
    push(6 * DIV, 0, "R5");
    run_op(4'b1110, 8'h01, c);
    finish_op();

    // R6 write bytes, LSB first
    foreach (pat[i]) pat[i] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      pat = (k == 0) ? 8'hA5 : 8'h3C;
      for (int i = 0; i < 8; i++) push((pat[i] ? 6 : 60) * DIV, (i == 0) ? 0 : 75 * DIV, "R6");
      run_op(4'b1111, pat, c);
      chk(c == 600 * DIV + 1, "R3 byte duration", c, 600 * DIV + 1);
      finish_op();
    end

    // R8 read bytes
    for (int k = 0; k < 2; k++) begin
      pat = (k == 0) ? 8'h3C : 8'hC5;
      dev_mode = 2; dev_bits = pat; dev_idx = 0;
      for (int i = 0; i < 8; i++) push(6 * DIV, (i == 0) ? 0 : 75 * DIV, "R8");
      run_op(4'b1101, 8'h00, c);
      chk(rx_data == pat, "R8 read byte", int'(rx_data), int'(pat));
      finish_op();
    end

    // R7 read bit: bit 0 only, upper bits cleared
    dev_bits = 8'h01; dev_idx = 0; push(6 * DIV, 0, "R7");
    run_op(4'b1100, 8'h00, c);
    chk(rx_data == 8'h01, "R7 read bit one", int'(rx_data), 1);
    finish_op();
    dev_bits = 8'hFE; dev_idx = 0; push(6 * DIV, 0, "R7");
    run_op(4'b1100, 8'hFF, c);
    chk(rx_data == 8'h00, "R7 read bit zero", int'(rx_data), 0);
    finish_op();
    dev_mode = 0;

    // R2 unknown opcode
    run_op(4'b0110, 8'h55, c);
    chk(c == 1, "R2 unknown opcode finishes", c, 1);
    chk(rx_data == 8'h00, "R2 rx unchanged", int'(rx_data), 0);
    finish_op();

    // R11 collision: go edge in the soft reset cycle
    @(negedge clk);
    go = 1'b1; soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    repeat (100 * DIV) @(negedge clk);
    chk(done == 1'b0 && bus_oe == 1'b0, "R11 collided go discarded", {done, bus_oe}, 0);
    chk(ready == 1'b1, "R9 no launch without edge", int'(ready), 1);
    go = 1'b0;

    // R11 abort a reset pulse midway
    push(-1, 0, "R11");
    @(negedge clk);
    opcode = 4'b1000; go = 1'b1;
    repeat (200) @(negedge clk);
    chk(bus_oe == 1'b1, "R4 line held low", int'(bus_oe), 1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(bus_oe == 1'b0 && done == 1'b0, "R11 abort releases", {bus_oe, done}, 0);
    go = 1'b0;
    repeat (2000) @(negedge clk);
    chk(exp_w.size() == 0, "R11 no pulse after abort", exp_w.size(), 0);

    push(6 * DIV, 0, "R11");
    run_op(4'b1110, 8'h01, c);
    chk(c == 75 * DIV + 1, "R11 recovers after abort", c, 75 * DIV + 1);
    finish_op();

    summary();
    $finish;
  end
endmodule